// File: doc/BRIEF.md
# Video Sync Timing Generator with Master and Slave Roles

This block keeps the horizontal and vertical timing of a raster video port. A mode input picks its role. As master it counts pixels and lines against programmed totals and drives active-low horizontal and vertical sync pulses of programmed width. It also drives an output enable, so the sync pins can be wired as bidirectional pads. As slave it releases the pins and samples the external sync lines through a two-flop synchronizer. A falling horizontal edge restarts its pixel counter and a falling vertical edge restarts its line counter.

In both roles the same counters feed the pixel and line position outputs and an active-region qualifier. The qualifier opens after a programmed horizontal lead-in, measured from the sync fall, and stays open for a programmed number of 8-pixel blocks. On lines, it opens after a programmed vertical lead-in and stays open for a programmed number of lines. All timing fields are captured together from a parallel load strobe.

Top module: `vidSyncTimer`

## Requirements
- R1: After reset, pixelPos and linePos are 0, hSyncOut and vSyncOut are 1, activeRegion is 0, and every timing field reads as 0.
- R2: In the cycle cfgLoad is high, all eight timing fields are captured at the clock edge. The new values govern the counters from the next edge on, and the old values govern the load edge itself.
- R3: In master mode pixelPos steps by one each clock from 0 to cfgHTotal-1 and then returns to 0. linePos advances by one exactly when pixelPos returns to 0, and returns to 0 after cfgVTotal-1. A total of 0 or 1 holds the counter at 0.
- R4: In master mode hSyncOut is 0 exactly while pixelPos < cfgHPulse, and vSyncOut is 0 exactly while linePos < cfgVPulse. A pulse width of 0 keeps the line at 1.
- R5: syncOe equals isMaster. While isMaster is 0, hSyncOut and vSyncOut are held at 1.
- R6: In slave mode, a 1-to-0 change of hSyncIn, held at least two clocks, makes pixelPos read 0 after the third rising edge following the change, and linePos advance by one on that same edge. pixelPos then counts up by one per clock.
- R7: In slave mode, a 1-to-0 change of vSyncIn makes linePos read 0 after the third rising edge following the change. This takes priority over a simultaneous horizontal fall.
- R8: In slave mode the counters never wrap. Without a horizontal fall, pixelPos stops at its all-ones value (4095 at the default 12-bit width).
- R9: activeRegion is 1 exactly when cfgHLead <= pixelPos < cfgHLead + 8*cfgHBlocks and cfgVLead <= linePos < cfgVLead + cfgVLines. The horizontal window length is counted in 8-pixel blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 selects the master role, 0 the slave role |
| cfgLoad | input | 1 | Captures all timing fields at the clock edge |
| cfgHTotal | input | H_W | Pixels per line |
| cfgHPulse | input | H_W | Horizontal sync width in pixels |
| cfgHLead | input | H_W | Pixels from sync fall to first active pixel |
| cfgHBlocks | input | H_W-3 | Active width in 8-pixel blocks |
| cfgVTotal | input | V_W | Lines per frame |
| cfgVPulse | input | V_W | Vertical sync width in lines |
| cfgVLead | input | V_W | Lines from sync fall to first active line |
| cfgVLines | input | V_W | Active lines per frame |
| hSyncIn | input | 1 | External horizontal sync, active low |
| vSyncIn | input | 1 | External vertical sync, active low |
| hSyncOut | output | 1 | Generated horizontal sync, active low |
| vSyncOut | output | 1 | Generated vertical sync, active low |
| syncOe | output | 1 | Drive enable for both sync pads |
| activeRegion | output | 1 | High inside the active window |
| pixelPos | output | H_W | Current pixel counter |
| linePos | output | V_W | Current line counter |

## Verification
The master role is swept cycle by cycle over whole frames for two small timings, and the bench model is switched at the load edge. The first timing has interior lead-ins and pulse widths. The second has a zero pulse width, a vertical pulse that fills the frame, a zero horizontal lead-in and a vertical window that runs past the total. Together they separate off-by-one errors at the wrap, the pulse edges and both window edges, and they show whether the width is counted in 8-pixel blocks or in pixels. The slave role is driven with isolated horizontal falls, a vertical fall that coincides with a horizontal one, and a long quiet stretch. These show the synchronizer latency, the priority between the two falls and the saturation of the pixel counter.

// File: rtl/vidSyncPkg.sv
package vidSyncPkg;
  typedef struct packed {
    logic hClear;
    logic hInc;
    logic vClear;
    logic vInc;
  } syncStrobes_t;
endpackage

// File: rtl/vidSyncCtrl.sv
module vidSyncCtrl
  import vidSyncPkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           isMaster,
  input  logic           hSyncIn,
  input  logic           vSyncIn,
  input  logic [H_W-1:0] hCnt,
  input  logic [V_W-1:0] vCnt,
  input  logic [H_W-1:0] hTotal,
  input  logic [V_W-1:0] vTotal,
  output syncStrobes_t   strobes
);
  localparam logic [H_W-1:0] H_MAX = '1;
  localparam logic [V_W-1:0] V_MAX = '1;

  logic [2:0] hShift;
  logic [2:0] vShift;
  logic       hFall;
  logic       vFall;
  logic       hWrap;
  logic       vWrap;

  // two synchronizer stages plus one history stage per sync input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hShift <= 3'b111;
      vShift <= 3'b111;
    end else begin
      hShift <= {hShift[1:0], hSyncIn};
      vShift <= {vShift[1:0], vSyncIn};
    end
  end

  assign hFall = hShift[2] & ~hShift[1];
  assign vFall = vShift[2] & ~vShift[1];

  assign hWrap = ({1'b0, hCnt} + 1'b1) >= {1'b0, hTotal};
  assign vWrap = ({1'b0, vCnt} + 1'b1) >= {1'b0, vTotal};

  always_comb begin
    strobes = '0;
    if (isMaster) begin
      strobes.hClear = hWrap;
      strobes.hInc   = ~hWrap;
      strobes.vClear = hWrap & vWrap;
      strobes.vInc   = hWrap & ~vWrap;
    end else begin
      strobes.hClear = hFall;
      strobes.hInc   = ~hFall & (hCnt != H_MAX);
      strobes.vClear = vFall;
      strobes.vInc   = ~vFall & hFall & (vCnt != V_MAX);
    end
  end
endmodule

// File: rtl/vidSyncDatapath.sv
module vidSyncDatapath
  import vidSyncPkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           isMaster,
  input  logic           cfgLoad,
  input  logic [H_W-1:0] cfgHTotal,
  input  logic [H_W-1:0] cfgHPulse,
  input  logic [H_W-1:0] cfgHLead,
  input  logic [H_W-4:0] cfgHBlocks,
  input  logic [V_W-1:0] cfgVTotal,
  input  logic [V_W-1:0] cfgVPulse,
  input  logic [V_W-1:0] cfgVLead,
  input  logic [V_W-1:0] cfgVLines,
  input  syncStrobes_t   strobes,
  output logic [H_W-1:0] hCnt,
  output logic [V_W-1:0] vCnt,
  output logic [H_W-1:0] hTotal,
  output logic [V_W-1:0] vTotal,
  output logic           hSyncOut,
  output logic           vSyncOut,
  output logic           activeRegion
);
  localparam int BLK_SHIFT = 3;

  logic [H_W-1:0] hPulse;
  logic [H_W-1:0] hLead;
  logic [H_W-4:0] hBlocks;
  logic [V_W-1:0] vPulse;
  logic [V_W-1:0] vLead;
  logic [V_W-1:0] vLines;
  logic [H_W:0]   hEnd;
  logic [V_W:0]   vEnd;
  logic           hInside;
  logic           vInside;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hTotal  <= '0;
      hPulse  <= '0;
      hLead   <= '0;
      hBlocks <= '0;
      vTotal  <= '0;
      vPulse  <= '0;
      vLead   <= '0;
      vLines  <= '0;
    end else if (cfgLoad) begin
      hTotal  <= cfgHTotal;
      hPulse  <= cfgHPulse;
      hLead   <= cfgHLead;
      hBlocks <= cfgHBlocks;
      vTotal  <= cfgVTotal;
      vPulse  <= cfgVPulse;
      vLead   <= cfgVLead;
      vLines  <= cfgVLines;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      if (strobes.hClear)    hCnt <= '0;
      else if (strobes.hInc) hCnt <= hCnt + 1'b1;
      if (strobes.vClear)    vCnt <= '0;
      else if (strobes.vInc) vCnt <= vCnt + 1'b1;
    end
  end

  assign hEnd    = {1'b0, hLead} + {1'b0, hBlocks, {BLK_SHIFT{1'b0}}};
  assign vEnd    = {1'b0, vLead} + {1'b0, vLines};
  assign hInside = (hCnt >= hLead) && ({1'b0, hCnt} < hEnd);
  assign vInside = (vCnt >= vLead) && ({1'b0, vCnt} < vEnd);
  assign activeRegion = hInside & vInside;

  assign hSyncOut = ~(isMaster & (hCnt < hPulse));
  assign vSyncOut = ~(isMaster & (vCnt < vPulse));
endmodule

// File: rtl/vidSyncTimer.sv
module vidSyncTimer
  import vidSyncPkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           isMaster,
  input  logic           cfgLoad,
  input  logic [H_W-1:0] cfgHTotal,
  input  logic [H_W-1:0] cfgHPulse,
  input  logic [H_W-1:0] cfgHLead,
  input  logic [H_W-4:0] cfgHBlocks,
  input  logic [V_W-1:0] cfgVTotal,
  input  logic [V_W-1:0] cfgVPulse,
  input  logic [V_W-1:0] cfgVLead,
  input  logic [V_W-1:0] cfgVLines,
  input  logic           hSyncIn,
  input  logic           vSyncIn,
  output logic           hSyncOut,
  output logic           vSyncOut,
  output logic           syncOe,
  output logic           activeRegion,
  output logic [H_W-1:0] pixelPos,
  output logic [V_W-1:0] linePos
);
  syncStrobes_t   strobes;
  logic [H_W-1:0] hCnt;
  logic [V_W-1:0] vCnt;
  logic [H_W-1:0] hTotal;
  logic [V_W-1:0] vTotal;

  vidSyncCtrl #(.H_W(H_W), .V_W(V_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .hCnt(hCnt), .vCnt(vCnt), .hTotal(hTotal), .vTotal(vTotal),
    .strobes(strobes)
  );

  vidSyncDatapath #(.H_W(H_W), .V_W(V_W)) i_dp (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .cfgLoad(cfgLoad),
    .cfgHTotal(cfgHTotal), .cfgHPulse(cfgHPulse), .cfgHLead(cfgHLead),
    .cfgHBlocks(cfgHBlocks), .cfgVTotal(cfgVTotal), .cfgVPulse(cfgVPulse),
    .cfgVLead(cfgVLead), .cfgVLines(cfgVLines), .strobes(strobes),
    .hCnt(hCnt), .vCnt(vCnt), .hTotal(hTotal), .vTotal(vTotal),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .activeRegion(activeRegion)
  );

  assign syncOe   = isMaster;
  assign pixelPos = hCnt;
  assign linePos  = vCnt;
endmodule

// File: rtl/vidSyncTimer_chk.sv
module vidSyncTimer_chk #(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input logic           clk,
  input logic           rstN,
  input logic           isMaster,
  input logic           syncOe,
  input logic           hSyncOut,
  input logic           vSyncOut,
  input logic [H_W-1:0] pixelPos,
  input logic [V_W-1:0] linePos
);
  logic started;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  // R5
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncOe |-> (hSyncOut && vSyncOut));

  // R3
  master_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(isMaster) && pixelPos != '0) |-> (pixelPos == $past(pixelPos) + 1'b1));

  // R3
  master_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(isMaster) && linePos != $past(linePos)) |-> (pixelPos == '0));

  // R6
  slave_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !$past(isMaster) && linePos != $past(linePos) && linePos != '0) |-> (pixelPos == '0));

  // R8
  slave_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !$past(isMaster) && pixelPos != '0) |->
      (pixelPos == $past(pixelPos) + 1'b1 || pixelPos == $past(pixelPos)));
endmodule

bind vidSyncTimer vidSyncTimer_chk #(.H_W(H_W), .V_W(V_W)) i_chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster), .syncOe(syncOe),
  .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .pixelPos(pixelPos), .linePos(linePos)
);

// File: tb/test_vidSyncTimer.sv
`timescale 1ns/1ps
module test_vidSyncTimer;
  localparam int H_W = 12;
  localparam int V_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b0;
  logic cfgLoad = 1'b0;
  logic [H_W-1:0] cfgHTotal = '0, cfgHPulse = '0, cfgHLead = '0;
  logic [H_W-4:0] cfgHBlocks = '0;
  logic [V_W-1:0] cfgVTotal = '0, cfgVPulse = '0, cfgVLead = '0, cfgVLines = '0;
  logic hSyncIn = 1'b1, vSyncIn = 1'b1;
  logic hSyncOut, vSyncOut, syncOe, activeRegion;
  logic [H_W-1:0] pixelPos;
  logic [V_W-1:0] linePos;

  int nChecks = 0;
  int nFails = 0;
  // bench model of effective timing and counters
  int mHT = 0, mHP = 0, mHL = 0, mHB = 0, mVT = 0, mVP = 0, mVL = 0, mVN = 0;
  int mH = 0, mV = 0;

  always #5 clk = ~clk;

  vidSyncTimer #(.H_W(H_W), .V_W(V_W)) i_vidSyncTimer (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .cfgLoad(cfgLoad),
    .cfgHTotal(cfgHTotal), .cfgHPulse(cfgHPulse), .cfgHLead(cfgHLead),
    .cfgHBlocks(cfgHBlocks), .cfgVTotal(cfgVTotal), .cfgVPulse(cfgVPulse),
    .cfgVLead(cfgVLead), .cfgVLines(cfgVLines), .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .syncOe(syncOe),
    .activeRegion(activeRegion), .pixelPos(pixelPos), .linePos(linePos)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge of the master model, using the timing in force before the edge
  task automatic stepMaster();
    if (mH + 1 >= mHT) begin
      mH = 0;
      mV = (mV + 1 >= mVT) ? 0 : mV + 1;
    end else begin
      mH = mH + 1;
    end
  endtask

  task automatic load(input int ht, hp, hl, hb, vt, vp, vl, vn);
    cfgHTotal = ht[H_W-1:0]; cfgHPulse = hp[H_W-1:0]; cfgHLead = hl[H_W-1:0];
    cfgHBlocks = hb[H_W-4:0]; cfgVTotal = vt[V_W-1:0]; cfgVPulse = vp[V_W-1:0];
    cfgVLead = vl[V_W-1:0]; cfgVLines = vn[V_W-1:0];
    cfgLoad = 1'b1;
    @(negedge clk);
    stepMaster();  // R2: old timing governs the load edge
    mHT = ht; mHP = hp; mHL = hl; mHB = hb; mVT = vt; mVP = vp; mVL = vl; mVN = vn;
    cfgLoad = 1'b0;
  endtask

  task automatic sweepMaster(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      chk("R3 pixelPos", pixelPos, mH);
      chk("R3 linePos", linePos, mV);
      chk("R4 hSyncOut", hSyncOut, (mH < mHP) ? 0 : 1);
      chk("R4 vSyncOut", vSyncOut, (mV < mVP) ? 0 : 1);
      chk("R9 activeRegion", activeRegion,
          (mH >= mHL && mH < mHL + 8 * mHB && mV >= mVL && mV < mVL + mVN) ? 1 : 0);
      chk("R5 syncOe master", syncOe, 1);
      @(negedge clk);
      stepMaster();
    end
  endtask

  task automatic hPulse(input int lowCycles, input int highCycles);
    hSyncIn = 1'b0;
    repeat (lowCycles) @(negedge clk);
    hSyncIn = 1'b1;
    repeat (highCycles) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    int lineBefore;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pixelPos", pixelPos, 0);
    chk("R1 linePos", linePos, 0);
    chk("R1 hSyncOut", hSyncOut, 1);
    chk("R1 vSyncOut", vSyncOut, 1);
    chk("R1 activeRegion", activeRegion, 0);
    rstN = 1'b1;
    isMaster = 1'b1;
    @(negedge clk);
    stepMaster();
    // R1: zero timing fields keep counters at 0 and sync high
    chk("R1 zero cfg pixelPos", pixelPos, 0);
    chk("R1 zero cfg hSyncOut", hSyncOut, 1);

    // R2 R3 R4 R9: first timing, interior edges
    load(20, 3, 5, 1, 6, 1, 2, 3);
    sweepMaster(2 * 20 * 6 + 7);
    // R2 R3 R4 R9: second timing loaded mid-frame, boundary values
    load(24, 0, 0, 2, 4, 4, 3, 5);
    sweepMaster(2 * 24 * 4 + 5);

    // slave role
    isMaster = 1'b0;
    @(negedge clk);
    chk("R5 syncOe slave", syncOe, 0);
    chk("R5 hSyncOut slave", hSyncOut, 1);
    chk("R5 vSyncOut slave", vSyncOut, 1);

    // R7 with simultaneous horizontal fall
    hSyncIn = 1'b0; vSyncIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 linePos cleared", linePos, 0);
    chk("R6 pixelPos cleared", pixelPos, 0);
    hSyncIn = 1'b1; vSyncIn = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 pixelPos counts", pixelPos, 5);

    // R6 isolated horizontal falls
    for (int k = 1; k <= 4; k++) begin
      lineBefore = linePos;
      hSyncIn = 1'b0;
      repeat (2) @(negedge clk);
      chk("R6 line held before latency", linePos, lineBefore);
      @(negedge clk);
      chk("R6 pixelPos cleared", pixelPos, 0);
      chk("R6 linePos advanced", linePos, lineBefore + 1);
      hSyncIn = 1'b1;
      repeat (7) @(negedge clk);
      chk("R6 pixelPos counts", pixelPos, 7);
      chk("R5 hSyncOut slave", hSyncOut, 1);
    end
    // R9 in slave role: window of second timing, line 4 inside 3..7, pixel 7 inside 0..15
    chk("R9 activeRegion slave", activeRegion, 1);
    // R8 saturation
    lineBefore = linePos;
    repeat (4100) @(negedge clk);
    chk("R8 pixelPos saturates", pixelPos, 4095);
    chk("R8 linePos unchanged", linePos, lineBefore);
    chk("R9 outside horizontal window", activeRegion, 0);
    hPulse(2, 3);
    chk("R6 after saturation", pixelPos, 2);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule